// File: doc/BRIEF.md
# Dual-Role SPI Byte Exchanger

This block moves one byte at a time over a four-wire serial link. Every transfer is full duplex. Each bit sent on `sdo` is paired with a bit taken from `sdi`. Firmware sees a single data buffer. A write loads the outgoing byte into the shift register. The read port shows a separate holding register that only ever contains a complete incoming byte.

With `mode_master` high, the block drives `sck_o` itself and starts a transfer as soon as firmware writes the buffer. With `mode_master` low, it is a follower. Firmware preloads the buffer, and the block shifts on the external `sck_i` while `ss_n` is low. The follower's inputs pass through two-flop synchronizers.

Clocking is mode 0 (SCK idles low), most significant bit first. Incoming data is sampled on the rising SCK edge, and outgoing data advances on the falling edge. Three status flags are provided:
- buffer full
- write collision
- follower overflow

An overflow freezes the follower's receive side until firmware clears it.

Top module: `spi_xchg`

## Requirements
- R1: With `mode_master`=1, a write while idle starts an 8-bit exchange. `busy` rises on the cycle after the write. `sck_o` toggles every CLK_DIV/2 clocks and rests low whenever `busy` is 0. `done` appears exactly 8*CLK_DIV clocks after the write edge.
- R2: Exchanges run MSB first in mode 0. `sdo` holds the current outgoing bit and changes only after a falling SCK edge. `sdi` is sampled at rising SCK edges. After an exchange, the remote side has received the written byte, and `rd_data` holds the byte the remote side sent.
- R3: With `mode_master`=0, a byte written while idle is shifted out on `sdo` as an external master clocks `sck_i` with `ss_n` low (active low). The byte completes on the eighth falling edge of `sck_i`.
- R4: A write while `busy` is 1 is discarded. The byte being shifted out is unchanged, and `wcol` is set on the next cycle. A `clr_wcol` pulse clears it.
- R5: `rd_data` shows the last completely received byte. It never shows partial shift contents, and it changes only in the cycle that `done` is high.
- R6: In master mode, a new byte replaces an unread one in the holding register. `ovf` is never raised.
- R7: In follower mode, if a byte completes while `buf_full` is 1, `ovf` is set and the holding register keeps its old value. While `ovf` is 1, later bytes are ignored. A `clr_ovf` pulse resumes reception.
- R8: `buf_full` sets when a byte enters the holding register. It clears on the cycle after an `rd_en` pulse.
- R9: Raising `ss_n` in the middle of a follower byte discards that byte. It does not pulse `done`, does not touch the holding register or `buf_full`, and resets the bit count so that the next byte is received whole.
- R10: `done` is a single-cycle pulse issued once for every completed byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_master | input | 1 | 1 = drive SCK, 0 = follow external SCK |
| wr_en | input | 1 | Firmware write strobe for the data buffer |
| wr_data | input | W | Byte to transmit |
| rd_en | input | 1 | Firmware read strobe; clears buf_full |
| rd_data | output | W | Last complete received byte |
| clr_wcol | input | 1 | Clears the write-collision flag |
| clr_ovf | input | 1 | Clears the overflow flag |
| busy | output | 1 | Exchange in progress |
| done | output | 1 | One-cycle pulse at the end of each byte |
| buf_full | output | 1 | Unread byte in the holding register |
| wcol | output | 1 | Write collided with an exchange |
| ovf | output | 1 | Follower overflow; reception frozen |
| sck_o | output | 1 | Generated SCK in master mode |
| sck_i | input | 1 | External SCK in follower mode |
| ss_n | input | 1 | Follower select, active low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |

## Verification
The assertions assume that `mode_master` changes only while `busy` is 0. They also assume that the external SCK and select change slowly enough for the two-flop synchronizers to resolve every edge. The bench switches the role only between transfers. It holds each follower SCK phase for six system clocks and moves `ss_n` only while SCK is low. Firmware strobes stay one cycle wide.

// File: rtl/spi_xchg.sv
module spi_xchg #(
  parameter int W       = 8,
  parameter int CLK_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mode_master,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rd_en,
  output logic [W-1:0] rd_data,
  input  logic         clr_wcol,
  input  logic         clr_ovf,
  output logic         busy,
  output logic         done,
  output logic         buf_full,
  output logic         wcol,
  output logic         ovf,
  output logic         sck_o,
  input  logic         sck_i,
  input  logic         ss_n,
  input  logic         sdi,
  output logic         sdo
);
  localparam int HALF = CLK_DIV / 2;
  localparam int HW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam int BW   = (W > 1) ? $clog2(W) : 1;

  logic [2:0]    sck_s;
  logic [1:0]    ss_s, sdi_s;
  logic          act, sck_r, samp;
  logic [HW-1:0] divcnt;
  logic [BW-1:0] bitc;
  logic [W-1:0]  shreg, hold;

  wire s_sel  = ~ss_s[1];
  wire s_rise = sck_s[1] & ~sck_s[2];
  wire s_fall = ~sck_s[1] & sck_s[2];
  wire tick   = mode_master && act && divcnt == '0;
  wire rise   = mode_master ? (tick && !sck_r) : (s_sel && s_rise);
  wire fall   = mode_master ? (tick && sck_r)  : (act && s_sel && s_fall);
  wire abort  = !mode_master && act && !s_sel;
  wire last   = fall && bitc == BW'(W - 1);
  wire load   = wr_en && !act;
  wire ovf_set = last && !mode_master && !ovf && buf_full && !rd_en;
  wire take   = last && (mode_master || (!ovf && !ovf_set));
  wire [W-1:0] rx_word = {shreg[W-2:0], samp};

  assign busy     = act;
  assign sck_o    = sck_r;
  assign sdo      = shreg[W-1];
  assign rd_data  = hold;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sck_s <= '0;
      ss_s  <= '1;
      sdi_s <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ss_s  <= {ss_s[0], ss_n};
      sdi_s <= {sdi_s[0], sdi};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act    <= 1'b0;
      sck_r  <= 1'b0;
      divcnt <= '0;
    end else begin
      if (mode_master) begin
        if (load) begin
          act    <= 1'b1;
          sck_r  <= 1'b0;
          divcnt <= HW'(HALF - 1);
        end else if (act) begin
          if (tick) begin
            sck_r  <= ~sck_r;
            divcnt <= HW'(HALF - 1);
          end else begin
            divcnt <= divcnt - 1'b1;
          end
          if (last) act <= 1'b0;
        end
      end else begin
        sck_r <= 1'b0;
        if (abort || last) act <= 1'b0;
        else if (rise)     act <= 1'b1;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      samp  <= 1'b0;
      bitc  <= '0;
      shreg <= '0;
    end else begin
      if (rise) samp <= mode_master ? sdi : sdi_s[1];
      if (load)                shreg <= wr_data;
      else if (fall && !last)  shreg <= rx_word;
      if (abort || last || !act) bitc <= '0;
      else if (fall)             bitc <= bitc + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      hold     <= '0;
      buf_full <= 1'b0;
      ovf      <= 1'b0;
      wcol     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= last;
      if (take) begin
        hold     <= rx_word;
        buf_full <= 1'b1;
      end else if (rd_en) begin
        buf_full <= 1'b0;
      end
      if (ovf_set)      ovf <= 1'b1;
      else if (clr_ovf) ovf <= 1'b0;
      if (wr_en && act) wcol <= 1'b1;
      else if (clr_wcol) wcol <= 1'b0;
    end

  AST_SCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !sck_o); // R1
  AST_WCOL_ON_BUSY: assert property (@(posedge clk) disable iff (!rst_n) wr_en && busy |=> wcol); // R4
  AST_HOLD_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n) !done |-> $stable(rd_data)); // R5
  AST_NO_MASTER_OVF: assert property (@(posedge clk) disable iff (!rst_n) mode_master |-> !$rose(ovf)); // R6
  AST_OVF_FREEZE: assert property (@(posedge clk) disable iff (!rst_n) ovf |-> $stable(rd_data)); // R7
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R10
endmodule

// File: tb/sim_spi_xchg.sv
module sim_spi_xchg;
  localparam int DIV = 4;
  localparam int H   = 6;

  logic clk = 0, rst_n = 0, mode_master = 1, wr_en = 0, rd_en = 0;
  logic clr_wcol = 0, clr_ovf = 0, sck_i = 0, ss_n = 1, s_sdi = 0;
  logic [7:0] wr_data = 0, rd_data, m_tx = 0, m_rx = 0;
  logic [2:0] mi = 0;
  logic busy, done, buf_full, wcol, ovf, sck_o, sdo, sdi, done_q = 0;
  int n_chk = 0, n_bad = 0, n_done = 0, n_wide = 0;
  logic [9:0] st = 0;

  always #2 clk = ~clk;

  assign sdi = mode_master ? m_tx[~mi] : s_sdi;
  always @(negedge sck_o) mi <= mi + 3'd1;
  always @(posedge sck_o) m_rx <= {m_rx[6:0], sdo};
  always @(posedge clk) begin
    if (done) n_done <= n_done + 1;
    if (done && done_q) n_wide <= n_wide + 1;
    done_q <= done;
  end

  spi_xchg #(.W(8), .CLK_DIV(DIV)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_master(mode_master), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .clr_wcol(clr_wcol), .clr_ovf(clr_ovf), .busy(busy),
    .done(done), .buf_full(buf_full), .wcol(wcol), .ovf(ovf), .sck_o(sck_o), .sck_i(sck_i),
    .ss_n(ss_n), .sdi(sdi), .sdo(sdo));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [9:0] m_next(input logic [9:0] s, input logic [7:0] nb);
    return {1'b1, s[8], nb};
  endfunction

  function automatic logic [9:0] s_next(input logic [9:0] s, input logic [7:0] nb);
    if (s[8]) return s;
    if (s[9]) return {2'b11, s[7:0]};
    return {2'b10, nb};
  endfunction

  task automatic fw_write(input logic [7:0] d);
    @(negedge clk); wr_data = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic fw_read();
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    st[9] = 1'b0;
  endtask

  task automatic pulse_clr_ovf();
    @(negedge clk); clr_ovf = 1;
    @(negedge clk); clr_ovf = 0;
    st[8] = 1'b0;
  endtask

  task automatic m_xfer(input logic [7:0] tx, input logic [7:0] stx, input bit collide, input bit rd);
    int n;
    logic [7:0] prev;
    prev = st[7:0];
    m_tx = stx;
    fw_write(tx);
    chk(busy === 1'b1, "R1 busy after write", busy, 1);
    n = 0;
    while (done !== 1'b1 && n < 1000) begin
      @(negedge clk);
      n++;
      wr_en = 0;
      if (collide && n == 3) begin wr_data = ~tx; wr_en = 1; end
      if (n == 6) chk(rd_data === prev, "R5 holding stable mid-exchange", rd_data, prev);
    end
    wr_en = 0;
    chk(n == 8 * DIV, "R1 exchange length", n, 8 * DIV);
    st = m_next(st, stx);
    chk(rd_data === st[7:0], "R2 received byte", rd_data, st[7:0]);
    chk(m_rx === tx, "R2/R4 byte seen by remote", m_rx, tx);
    chk(buf_full === 1'b1, "R8 full after byte", buf_full, 1);
    chk(ovf === 1'b0, "R6 no overflow in master", ovf, 0);
    chk(sck_o === 1'b0 && busy === 1'b0, "R1 idle after exchange", {busy, sck_o}, 0);
    if (collide) begin
      chk(wcol === 1'b1, "R4 collision flag", wcol, 1);
      @(negedge clk); clr_wcol = 1;
      @(negedge clk); clr_wcol = 0;
      chk(wcol === 1'b0, "R4 collision cleared", wcol, 0);
    end
    if (rd) begin
      fw_read();
      chk(buf_full === 1'b0, "R8 full clears on read", buf_full, 0);
    end
  endtask

  task automatic s_xfer(input logic [7:0] mo, input int nbits, output logic [7:0] cap);
    cap = 0;
    ss_n = 0;
    repeat (H) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      s_sdi = mo[7 - i];
      repeat (H) @(negedge clk);
      cap[7 - i] = sdo;
      sck_i = 1;
      repeat (H) @(negedge clk);
      sck_i = 0;
    end
    repeat (H) @(negedge clk);
    ss_n = 1;
    repeat (H) @(negedge clk);
  endtask

  task automatic s_check(input logic [7:0] tx, input logic [7:0] cap, input string tag);
    chk(cap === tx, {tag, " tx byte on sdo"}, cap, tx);
    chk(rd_data === st[7:0], {tag, " holding"}, rd_data, st[7:0]);
    chk(buf_full === st[9], {tag, " buf_full"}, buf_full, st[9]);
    chk(ovf === st[8], {tag, " ovf"}, ovf, st[8]);
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    logic [7:0] cap, a, b;
    int r, d0;
    r = $urandom(7);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk({busy, buf_full, wcol, ovf, sck_o, done} === 6'b0, "R8 reset state", {busy, buf_full, wcol, ovf, sck_o, done}, 0);

    m_xfer(8'hA5, 8'h3C, 0, 1);
    m_xfer(8'h00, 8'hFF, 1, 0);
    m_xfer(8'hFF, 8'h01, 0, 0);
    m_xfer(8'h80, 8'h7E, 0, 1);
    for (int i = 0; i < 16; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      m_xfer(a, b, ($urandom % 4) == 0, ($urandom % 2) == 0);
    end
    if (buf_full) fw_read();

    @(negedge clk); mode_master = 0;
    d0 = n_done;
    fw_write(8'hC3);
    s_xfer(8'h5A, 8, cap);
    st = s_next(st, 8'h5A);
    s_check(8'hC3, cap, "R3 follower exchange");
    chk(n_done == d0 + 1, "R10 one done per byte", n_done, d0 + 1);

    fw_read();
    fw_write(8'h96);
    fork
      s_xfer(8'h11, 8, cap);
      begin repeat (40) @(negedge clk); wr_data = 8'h00; wr_en = 1; @(negedge clk); wr_en = 0; end
    join
    st = s_next(st, 8'h11);
    s_check(8'h96, cap, "R4 follower collision");
    chk(wcol === 1'b1, "R4 follower wcol", wcol, 1);
    @(negedge clk); clr_wcol = 1; @(negedge clk); clr_wcol = 0;

    fw_write(8'h0F);
    s_xfer(8'h22, 8, cap);
    st = s_next(st, 8'h22);
    s_check(8'h0F, cap, "R7 overflow set");
    fw_write(8'hF0);
    s_xfer(8'h33, 8, cap);
    st = s_next(st, 8'h33);
    s_check(8'hF0, cap, "R7 frozen while ovf");
    fw_read();
    fw_write(8'h44);
    s_xfer(8'h55, 8, cap);
    st = s_next(st, 8'h55);
    s_check(8'h44, cap, "R7 still frozen after read");
    pulse_clr_ovf();
    fw_write(8'h66);
    s_xfer(8'h77, 8, cap);
    st = s_next(st, 8'h77);
    s_check(8'h66, cap, "R7 resumes after clear");

    fw_read();
    d0 = n_done;
    fw_write(8'h81);
    s_xfer(8'hE7, 3, cap);
    chk(n_done == d0, "R9 abort gives no done", n_done, d0);
    chk(busy === 1'b0, "R9 abort ends exchange", busy, 0);
    s_check(8'h81 & 8'hE0, cap & 8'hE0, "R9 abort keeps holding");
    fw_write(8'h18);
    s_xfer(8'hBD, 8, cap);
    st = s_next(st, 8'hBD);
    s_check(8'h18, cap, "R9 next byte whole");

    for (int i = 0; i < 10; i++) begin
      a = 8'($urandom); b = 8'($urandom);
      fw_write(a);
      s_xfer(b, 8, cap);
      st = s_next(st, b);
      s_check(a, cap, "R7 random follower");
      if (($urandom % 3) == 0) pulse_clr_ovf();
      if (($urandom % 2) == 0) fw_read();
    end

    chk(n_wide == 0, "R10 done single cycle", n_wide, 0);
    report();
    $finish;
  end
endmodule